// File: doc/BRIEF.md
# Low-Power-Aware Free-Running Capture Timer

This block is a 16-bit up counter that never resets itself during normal running, paired with one input-capture channel. The counter and the capture logic stay consistent while the chip moves between normal running, a wait mode and a stop mode. In wait mode the CPU clock is parked but the timer keeps counting. A capture can raise an interrupt request, and that request is the wake source that ends wait. In stop mode the count is frozen. The first valid capture edge seen during stop is only remembered. It turns into a visible flag with data only when stop ends through an interrupt wake. A reset discards the remembered edge and reloads the counter with 0xFFFC.

A small mode controller decides when the counter may tick. It also decides when a capture is taken live, held back, published or dropped. Its states are RUN, WAIT, STOP and STOP_ARMED, and its transitions are:
- RUN->STOP when stop_mode is high.
- RUN->WAIT when wait_mode is high and stop_mode is low.
- WAIT->STOP when stop_mode is high.
- WAIT->RUN when wait_mode is low.
- STOP->STOP_ARMED on a valid edge without irq_wake.
- STOP->RUN on irq_wake.
- STOP_ARMED->RUN on irq_wake.

Reset forces RUN. A minimal overflow flag marks the counter wrapping.

Top module: `lp_capture_timer`

## Requirements
- R1: While rst_n is low: count_o = 0xFFFC, capture_o = 0, cap_flag = 0, ovf_flag = 0 and irq_req = 0.
- R2: In RUN and WAIT the count rises by exactly one on every clock edge. It wraps from 0xFFFF to 0x0000.
- R3: A clock edge that samples stop_mode high in RUN or WAIT still increments the count. From then on the count holds its value for as long as the block is stopped.
- R4: edge_rise = 1 selects rising edges of cap_pin and edge_rise = 0 selects falling edges. The opposite edge is ignored.
  - cap_pin passes through two synchronizer flops.
  - If cap_pin changes to the active level in a cycle where count_o shows c, then from the third following clock edge onward capture_o = c + 2 and cap_flag = 1.
- R5: A valid edge during stop leaves cap_flag at 0, irq_req unchanged and capture_o unchanged.
- R6: When irq_wake is sampled high while stopped after a valid edge, cap_flag becomes 1 and capture_o takes the frozen count. The count does not tick on that edge and resumes on the next one. Later edges in stop are ignored.
- R7: Waking through irq_wake with no edge during stop leaves cap_flag at 0 and the count at its frozen value.
- R8: A reset during stop with an armed edge yields the R1 values. No flag and no data appear after reset is released.
- R9: A flag_clr pulse clears cap_flag on the next edge. A flag_clr in the same cycle as a new capture leaves cap_flag set, with the new data.
- R10: irq_req = irq_en AND (cap_flag OR ovf_flag). It is combinational and also serves as the wake request in wait mode.
- R11: ovf_flag becomes 1 on the edge where the count wraps to 0x0000. ovf_clr clears it, and a set wins over a clear.
- R12: stop_mode takes priority over wait_mode. Once stopped, only irq_wake or reset ends stop: dropping stop_mode alone keeps the count frozen. irq_wake outside stop has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock, one tick per edge outside stop |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_mode | input | 1 | Wait mode indicator |
| stop_mode | input | 1 | Stop mode indicator |
| irq_wake | input | 1 | Interrupt wake indication that ends stop |
| cap_pin | input | 1 | Asynchronous capture input |
| edge_rise | input | 1 | 1 = capture on rising edge, 0 = falling edge |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clear strobe for the capture flag |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| count_o | output | 16 | Counter value |
| capture_o | output | 16 | Capture register |
| cap_flag | output | 1 | Capture flag |
| ovf_flag | output | 1 | Overflow flag |
| irq_req | output | 1 | Interrupt / wake request |

## Verification
The contested cycle is the one where a capture edge reaches the capture register while a flag_clr strobe is applied. The bench times the strobe to the edge that latches the new data, then checks that the flag survives and carries the new value. The second collision is between the wake strobe and the frozen count. The bench checks that the count shown right after wake equals the frozen value and the captured value, and that it resumes only one edge later. Every capture, in both polarities, at several offsets and in both RUN and WAIT, is judged against the count read when the pin changed plus two.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_WAIT       = 2'd1,
        ST_STOP       = 2'd2,
        ST_STOP_ARMED = 2'd3
    } lpt_state_e;
endpackage

// File: rtl/lpt_edge_sync.sv
module lpt_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic edge_hit
);
    localparam int LAST = SYNC_STAGES;

    // sh[0..SYNC_STAGES-1] synchronize, sh[LAST] remembers previous level
    logic [LAST:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[LAST-1:0], pin};
    end

    logic lvl_now, lvl_old;
    always_comb begin
        lvl_now  = sh[LAST-1];
        lvl_old  = sh[LAST];
        edge_hit = rise_sel ? (lvl_now & ~lvl_old) : (~lvl_now & lvl_old);
    end

    // R4: a rising-edge detection can never repeat on consecutive cycles
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && rise_sel) |=> !(edge_hit && rise_sel));
endmodule

// File: rtl/lpt_counter.sv
module lpt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         ovf_clr,
    output logic [W-1:0] cnt,
    output logic         ovf_flag
);
    localparam logic [W-1:0] RESET_VAL = {{(W-2){1'b1}}, 2'b00};
    localparam logic [W-1:0] ALL_ONES  = '1;
    localparam logic [W-1:0] ONE       = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= RESET_VAL;
            ovf_flag <= 1'b0;
        end else begin
            if (tick_en) cnt <= cnt + ONE;
            if (tick_en && (cnt == ALL_ONES)) ovf_flag <= 1'b1;
            else if (ovf_clr)                 ovf_flag <= 1'b0;
        end
    end

    // R2: every enabled tick adds one
    p_tick_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> (cnt == $past(cnt) + ONE));
    // R3: no tick means the count holds
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt));
    // R11: a wrap always leaves the overflow flag set
    p_ovf_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cnt == ALL_ONES) |=> ovf_flag);
endmodule

// File: rtl/lpt_mode_ctrl.sv
module lpt_mode_ctrl
    import lpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stop_mode,
    input  logic         wait_mode,
    input  logic         irq_wake,
    input  logic         edge_hit,
    input  logic         flag_clr,
    input  logic [W-1:0] cnt,
    output logic         tick_en,
    output logic [W-1:0] cap_q,
    output logic         cap_flag
);
    lpt_state_e st_q, st_d;
    logic [W-1:0] arm_data;
    logic in_stop, live_take, wake_xfer, arm_now;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (stop_mode)      st_d = ST_STOP;
                else if (wait_mode) st_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (stop_mode)       st_d = ST_STOP;
                else if (!wait_mode) st_d = ST_RUN;
            end
            ST_STOP: begin
                if (irq_wake)      st_d = ST_RUN;
                else if (edge_hit) st_d = ST_STOP_ARMED;
            end
            ST_STOP_ARMED: begin
                if (irq_wake) st_d = ST_RUN;
            end
            default: st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        in_stop   = (st_q == ST_STOP) || (st_q == ST_STOP_ARMED);
        tick_en   = !in_stop;
        live_take = edge_hit && !in_stop;
        wake_xfer = irq_wake && in_stop;
        arm_now   = edge_hit && (st_q == ST_STOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_data <= '0;
            cap_q    <= '0;
            cap_flag <= 1'b0;
        end else begin
            if (arm_now) arm_data <= cnt;
            if (wake_xfer && (st_q == ST_STOP_ARMED)) begin
                cap_q    <= arm_data;
                cap_flag <= 1'b1;
            end else if (wake_xfer && arm_now) begin
                cap_q    <= cnt;
                cap_flag <= 1'b1;
            end else if (live_take) begin
                cap_q    <= cnt;
                cap_flag <= 1'b1;
            end else if (flag_clr) begin
                cap_flag <= 1'b0;
            end
        end
    end

    // R5: no flag appears while stop persists
    p_silent_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stop && !irq_wake) |=> !$rose(cap_flag));
    // R5: capture data untouched while stop persists
    p_cap_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stop && !irq_wake) |=> $stable(cap_q));
    // R9: a live capture wins over a simultaneous clear
    p_live_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && !in_stop) |=> cap_flag);
    // R6: waking after an armed edge publishes the flag
    p_wake_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STOP_ARMED && irq_wake) |=> cap_flag);
    // R12: irq_wake outside stop never changes the capture register
    p_wake_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_stop && !edge_hit) |=> $stable(cap_q));
endmodule

// File: rtl/lp_capture_timer.sv
module lp_capture_timer #(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wait_mode,
    input  logic         stop_mode,
    input  logic         irq_wake,
    input  logic         cap_pin,
    input  logic         edge_rise,
    input  logic         irq_en,
    input  logic         flag_clr,
    input  logic         ovf_clr,
    output logic [W-1:0] count_o,
    output logic [W-1:0] capture_o,
    output logic         cap_flag,
    output logic         ovf_flag,
    output logic         irq_req
);
    logic edge_hit;
    logic tick_en;

    lpt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (cap_pin),
        .rise_sel (edge_rise),
        .edge_hit (edge_hit)
    );

    lpt_mode_ctrl #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_mode (stop_mode),
        .wait_mode (wait_mode),
        .irq_wake  (irq_wake),
        .edge_hit  (edge_hit),
        .flag_clr  (flag_clr),
        .cnt       (count_o),
        .tick_en   (tick_en),
        .cap_q     (capture_o),
        .cap_flag  (cap_flag)
    );

    lpt_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .ovf_clr  (ovf_clr),
        .cnt      (count_o),
        .ovf_flag (ovf_flag)
    );

    assign irq_req = irq_en & (cap_flag | ovf_flag);

    // R10: a request never appears with interrupts disabled
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_en);
endmodule

// File: tb/sim_lp_capture_timer.sv
module sim_lp_capture_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, wait_mode, stop_mode, irq_wake, cap_pin, edge_rise;
    logic        irq_en, flag_clr, ovf_clr;
    logic [15:0] count_o, capture_o;
    logic        cap_flag, ovf_flag, irq_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    lp_capture_timer u0 (
        .clk(clk), .rst_n(rst_n), .wait_mode(wait_mode), .stop_mode(stop_mode),
        .irq_wake(irq_wake), .cap_pin(cap_pin), .edge_rise(edge_rise),
        .irq_en(irq_en), .flag_clr(flag_clr), .ovf_clr(ovf_clr),
        .count_o(count_o), .capture_o(capture_o), .cap_flag(cap_flag),
        .ovf_flag(ovf_flag), .irq_req(irq_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    endtask

    task automatic live_capture(input logic pol, input int k, input logic use_wait);
        logic [15:0] c0, c1;
        edge_rise = pol; cap_pin = ~pol; wait_mode = use_wait;
        cyc(4);
        clear_flag();
        chk("R9 clear", {15'd0, cap_flag}, 16'd0);
        chk("R10 irq low", {15'd0, irq_req}, 16'd0);
        c1 = count_o; cyc(3);
        chk("R2 tick", count_o, c1 + 16'd3);
        cyc(k);
        c0 = count_o;
        cap_pin = pol;
        cyc(1);
        chk("R4 latency", {15'd0, cap_flag}, 16'd0);
        cyc(2);
        chk("R4 flag", {15'd0, cap_flag}, 16'd1);
        chk("R4 data", capture_o, c0 + 16'd2);
        chk("R10 irq high", {15'd0, irq_req}, 16'd1);
        c1 = capture_o;
        cap_pin = ~pol;
        cyc(4);
        chk("R4 opposite ignored", capture_o, c1);
        wait_mode = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] c0, s;
        rst_n = 1'b0; wait_mode = 1'b0; stop_mode = 1'b0; irq_wake = 1'b0;
        cap_pin = 1'b0; edge_rise = 1'b1; irq_en = 1'b1; flag_clr = 1'b0; ovf_clr = 1'b0;
        cyc(3);
        chk("R1 count", count_o, 16'hFFFC);
        chk("R1 capture", capture_o, 16'h0000);
        chk("R1 flags", {14'd0, cap_flag, ovf_flag}, 16'd0);
        chk("R1 irq", {15'd0, irq_req}, 16'd0);
        rst_n = 1'b1;
        cyc(1); chk("R2 first tick", count_o, 16'hFFFD);
        cyc(2); chk("R2 near wrap", count_o, 16'hFFFF);
        chk("R11 before wrap", {15'd0, ovf_flag}, 16'd0);
        cyc(1); chk("R2 wrap", count_o, 16'h0000);
        chk("R11 set", {15'd0, ovf_flag}, 16'd1);
        irq_en = 1'b0; #1 chk("R10 masked", {15'd0, irq_req}, 16'd0);
        irq_en = 1'b1; #1 chk("R10 ovf irq", {15'd0, irq_req}, 16'd1);
        cyc(1);
        ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
        chk("R11 clear", {15'd0, ovf_flag}, 16'd0);

        // sweep: polarity, offset, run/wait
        for (int p = 0; p < 2; p++)
            for (int k = 0; k < 4; k++)
                live_capture(p[0], k, k[0]);

        // R9 collision: clear strobe on the capture edge
        edge_rise = 1'b1; cap_pin = 1'b0; cyc(4);
        chk("R9 flag preset", {15'd0, cap_flag}, 16'd1);
        c0 = count_o; cap_pin = 1'b1;
        cyc(2); flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
        chk("R9 set wins", {15'd0, cap_flag}, 16'd1);
        chk("R9 new data", capture_o, c0 + 16'd2);
        clear_flag();
        chk("R9 plain clear", {15'd0, cap_flag}, 16'd0);

        // stop with an edge, interrupt wake
        cap_pin = 1'b0; cyc(4);
        c0 = capture_o;
        s = count_o; stop_mode = 1'b1; cyc(1);
        chk("R3 entry tick", count_o, s + 16'd1);
        s = count_o; cyc(3);
        chk("R3 frozen", count_o, s);
        cap_pin = 1'b1; cyc(5);
        chk("R5 no flag", {15'd0, cap_flag}, 16'd0);
        chk("R5 no irq", {15'd0, irq_req}, 16'd0);
        chk("R5 capture kept", capture_o, c0);
        cap_pin = 1'b0; cyc(3); cap_pin = 1'b1; cyc(3);
        stop_mode = 1'b0; cyc(2);
        chk("R12 stop held", count_o, s);
        irq_wake = 1'b1; cyc(1); irq_wake = 1'b0;
        chk("R6 flag", {15'd0, cap_flag}, 16'd1);
        chk("R6 data", capture_o, s);
        chk("R6 no tick on wake", count_o, s);
        cyc(1); chk("R6 resume", count_o, s + 16'd1);

        // stop without an edge
        clear_flag();
        stop_mode = 1'b1; cyc(1); s = count_o; cyc(4);
        stop_mode = 1'b0; irq_wake = 1'b1; cyc(1); irq_wake = 1'b0;
        chk("R7 no flag", {15'd0, cap_flag}, 16'd0);
        chk("R7 count", count_o, s);

        // R12: stop over wait, irq_wake in run
        stop_mode = 1'b1; wait_mode = 1'b1; cyc(1); s = count_o; cyc(3);
        chk("R12 stop priority", count_o, s);
        stop_mode = 1'b0; wait_mode = 1'b0; irq_wake = 1'b1; cyc(1);
        c0 = count_o; c0 = c0; cyc(2); irq_wake = 1'b0;
        chk("R12 wake in run", count_o, s + 16'd2);
        chk("R12 flag untouched", {15'd0, cap_flag}, 16'd0);

        // stop with armed edge, reset exit
        cap_pin = 1'b0; cyc(4);
        stop_mode = 1'b1; cyc(2); cap_pin = 1'b1; cyc(4);
        rst_n = 1'b0; cap_pin = 1'b0; cyc(1);
        chk("R8 count", count_o, 16'hFFFC);
        chk("R8 flag", {15'd0, cap_flag}, 16'd0);
        chk("R8 capture", capture_o, 16'h0000);
        stop_mode = 1'b0; rst_n = 1'b1; cyc(3);
        chk("R8 after release", {15'd0, cap_flag}, 16'd0);
        chk("R8 counting", count_o, 16'hFFFF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule